// File: doc/BRIEF.md
# LED Channel Fault Supervisor

This block watches over a two-channel constant-current LED driver and the switching converter that feeds it. It takes comparator results that are already digital (per-channel LED pin low and LED pin high, three output-voltage level flags, undervoltage, over-temperature, overcurrent), the PWM dimming input, the enable input, a channel-2 disable input and a single-cycle pulse at each switching period. From these it produces per-channel enables, a global shutdown, a soft-start discharge request and two active-low fault flags meant to drive open-drain pads.

Two delayed faults share one qualification scheme that counts switching ticks. The first is the global short-circuit fault, raised when a running channel's pin sits low. The second is the per-channel LED short fault, raised when a pin sits high while the output voltage is low, and it only advances during the PWM high phase. An LED open fault (pin low while the output is near its overvoltage level) latches the affected channel at once. Every latched fault clears only on enable low or undervoltage. Overvoltage and overcurrent are level conditions and are never latched.

Top module: `led_fault_supervisor`

## Requirements
- R1: After reset with enable low, `ch_en_o` is 0, `shutdown_o` is 1, `ss_discharge_o` is 1 and both `fail1_n_o` and `fail2_n_o` are 1. Every asynchronous flag passes through SYNC_STAGES flops before use.
- R2: While any running channel has its low flag set, each `sw_tick_i` pulse advances a shared counter. On the QUAL_TICKS-th counted tick a short-circuit latch sets. That latch drives `shutdown_o` to 1, `ch_en_o` to 0 and `fail1_n_o` to 0.
- R3: If no running channel has its low flag set, the short-circuit counter returns to zero, so a later qualification needs a full QUAL_TICKS ticks again.
- R4: A running channel whose low flag is set while `ovp_open_lvl_i` is high latches as open without waiting for any tick. Its enable bit drops, `fail2_n_o` goes to 0 and the other channel stays enabled.
- R5: A running channel whose high flag is set while `ovp_short_lvl_i` is high latches as shorted on its QUAL_TICKS-th qualified tick. Only that channel's enable drops and `fail2_n_o` goes to 0. If the condition clears, that channel's counter returns to zero.
- R6: While the synchronised PWM input is low, ticks do not advance a channel's short counter, and the count already reached is held.
- R7: Latched short-circuit, open and short faults stay set until the enable input goes low or undervoltage is asserted.
- R8: `ss_discharge_o` is 1 while overvoltage (`ovp_trip_i`) or overcurrent is active, and returns to 0 when both release. Overvoltage also drives `fail1_n_o` to 0, and overcurrent does not.
- R9: Undervoltage or over-temperature drives `shutdown_o` to 1, `ch_en_o` to 0, `ss_discharge_o` to 1 and `fail1_n_o` to 0. Over-temperature alone is not latched.
- R10: With `ch2_off_i` high, channel index 1 is disabled (`ch_en_o[1]`=0). A disabled channel takes no part in open, short or short-circuit detection. Channel index 0 is always eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_i | input | 1 | Enable; low clears latched faults |
| uvlo_i | input | 1 | Undervoltage flag |
| tsd_i | input | 1 | Over-temperature flag |
| ocp_i | input | 1 | Overcurrent flag |
| ovp_trip_i | input | 1 | Output above overvoltage trip level |
| ovp_open_lvl_i | input | 1 | Output above open-qualification level |
| ovp_short_lvl_i | input | 1 | Output below short-qualification level |
| pwm_i | input | 1 | PWM dimming input |
| ch2_off_i | input | 1 | High disables channel index 1 |
| sw_tick_i | input | 1 | One-cycle pulse per switching period (synchronous) |
| led_lo_i | input | NUM_CH | Per-channel LED pin below low threshold |
| led_hi_i | input | NUM_CH | Per-channel LED pin above high threshold |
| ch_en_o | output | NUM_CH | Per-channel driver enable |
| shutdown_o | output | 1 | Global shutdown |
| ss_discharge_o | output | 1 | Soft-start discharge / stop switching |
| fail1_n_o | output | 1 | Active-low supply/converter fault flag |
| fail2_n_o | output | 1 | Active-low LED open/short flag |

## Verification
All 64 combinations of enable, undervoltage, over-temperature, overvoltage, overcurrent and channel-2 disable are swept with no LED flags set. This separates the level-driven outputs and shows that none of these conditions latches. Tick sequences stop one tick short of the limit, then finish on the next tick. Each sequence is repeated after a mid-count release, which separates a proper counter reset from a count that merely pauses. The short fault is also tried with PWM low between ticks, which tells holding apart from both advancing and resetting. Open faults are driven on an enabled channel and on a disabled one, and each latched fault is then cleared through enable or undervoltage.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
   // Global flags carried through the synchroniser, one bit each.
   typedef struct packed {
      logic en;
      logic uvlo;
      logic tsd;
      logic ocp;
      logic ovp_trip;
      logic ovp_open;
      logic ovp_short;
      logic pwm;
      logic ch2_off;
   } glob_flags_t;

   localparam int GLOB_W = $bits(glob_flags_t);
endpackage

// File: rtl/lfs_sync.sv
module lfs_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lfs_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else if (s == 0) stage_q[s] <= d;
         else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lfs_tick_qual.sv
module lfs_tick_qual #(
   parameter int LIMIT = 32770
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   input  logic adv,
   output logic done
);
   if (LIMIT < 2) begin : g_bad_limit
      $error("lfs_tick_qual: LIMIT must be at least 2");
   end

   localparam int CW = $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;
   logic          at_last;

   assign at_last = (cnt_q == LAST);
   assign done    = cond & adv & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!cond)  cnt_q <= '0;
      else if (adv)    cnt_q <= at_last ? '0 : cnt_q + 1'b1;
   end

   // R3
   qual_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cond |=> cnt_q == '0);
   // R6
   qual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond && !adv |=> $stable(cnt_q));
   // R2
   qual_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/led_fault_supervisor.sv
module led_fault_supervisor
   import lfs_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int QUAL_TICKS  = 32770,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              uvlo_i,
   input  logic              tsd_i,
   input  logic              ocp_i,
   input  logic              ovp_trip_i,
   input  logic              ovp_open_lvl_i,
   input  logic              ovp_short_lvl_i,
   input  logic              pwm_i,
   input  logic              ch2_off_i,
   input  logic              sw_tick_i,
   input  logic [NUM_CH-1:0] led_lo_i,
   input  logic [NUM_CH-1:0] led_hi_i,
   output logic [NUM_CH-1:0] ch_en_o,
   output logic              shutdown_o,
   output logic              ss_discharge_o,
   output logic              fail1_n_o,
   output logic              fail2_n_o
);
   if (NUM_CH < 2) begin : g_bad_ch
      $error("led_fault_supervisor: NUM_CH must be at least 2");
   end

   localparam int SW = GLOB_W + 2*NUM_CH;

   glob_flags_t      g_raw, g_s;
   logic [NUM_CH-1:0] lo_s, hi_s;
   logic [SW-1:0]    sync_d, sync_q;

   assign g_raw = '{en: en_i, uvlo: uvlo_i, tsd: tsd_i, ocp: ocp_i,
                    ovp_trip: ovp_trip_i, ovp_open: ovp_open_lvl_i,
                    ovp_short: ovp_short_lvl_i, pwm: pwm_i, ch2_off: ch2_off_i};
   assign sync_d = {g_raw, led_lo_i, led_hi_i};

   lfs_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sync_d), .q(sync_q));

   assign {g_s, lo_s, hi_s} = sync_q;

   // Fault clearing and global run state
   logic clear_s, scp_l, run, scp_cond, scp_done;
   logic [NUM_CH-1:0] act, ch_run, open_l, short_l, short_done;

   assign clear_s = ~g_s.en | g_s.uvlo;
   assign run     = g_s.en & ~g_s.uvlo & ~g_s.tsd & ~scp_l;

   // Global short-circuit qualification
   assign scp_cond = |(ch_run & lo_s);

   lfs_tick_qual #(.LIMIT(QUAL_TICKS)) u_scp_qual (
      .clk(clk), .rst_n(rst_n), .cond(scp_cond), .adv(sw_tick_i),
      .done(scp_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        scp_l <= 1'b0;
      else if (clear_s)  scp_l <= 1'b0;
      else if (scp_done) scp_l <= 1'b1;
   end

   // Per-channel open and short supervision
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic short_cond;

      if (i == 0) begin : g_fixed
         assign act[i] = 1'b1;
      end else begin : g_switchable
         assign act[i] = ~g_s.ch2_off;
      end

      assign ch_run[i]  = act[i] & run & ~open_l[i] & ~short_l[i];
      assign short_cond = ch_run[i] & hi_s[i] & g_s.ovp_short;

      lfs_tick_qual #(.LIMIT(QUAL_TICKS)) u_short_qual (
         .clk(clk), .rst_n(rst_n), .cond(short_cond),
         .adv(sw_tick_i & g_s.pwm), .done(short_done[i]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_l[i]  <= 1'b0;
            short_l[i] <= 1'b0;
         end else if (clear_s) begin
            open_l[i]  <= 1'b0;
            short_l[i] <= 1'b0;
         end else begin
            if (ch_run[i] & lo_s[i] & g_s.ovp_open) open_l[i]  <= 1'b1;
            if (short_done[i])                      short_l[i] <= 1'b1;
         end
      end

      // R4 R10
      open_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(open_l[i]) |-> $past(act[i] && g_s.ovp_open && lo_s[i]));
      // R5 R6
      short_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(short_l[i]) |-> $past(g_s.pwm && sw_tick_i && act[i]));
   end

   // Outputs
   assign ch_en_o        = ch_run;
   assign shutdown_o     = ~run;
   assign ss_discharge_o = ~run | g_s.ovp_trip | g_s.ocp;
   assign fail1_n_o      = ~(g_s.uvlo | g_s.tsd | g_s.ovp_trip | scp_l);
   assign fail2_n_o      = ~(|open_l | |short_l);

   // R7
   scp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scp_l && !clear_s |=> scp_l);
   // R2
   scp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scp_l) |-> $past(scp_cond && sw_tick_i));
   // R7
   ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_s && (|(open_l | short_l)) |=> !fail2_n_o);
endmodule

// File: tb/test_led_fault_supervisor.sv
module test_led_fault_supervisor;
   localparam int Q = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 0, uvlo = 0, tsd = 0, ocp = 0, ovp_trip = 0, ovp_open = 0;
   logic ovp_short = 0, pwm = 0, ch2_off = 0, tick = 0;
   logic [1:0] lo = 2'b00, hi = 2'b00;
   logic [1:0] ch_en;
   logic shutdown, ssd, f1n, f2n;

   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   led_fault_supervisor #(.NUM_CH(2), .QUAL_TICKS(Q), .SYNC_STAGES(2)) i_led_fault_supervisor (
      .clk(clk), .rst_n(rst_n), .en_i(en), .uvlo_i(uvlo), .tsd_i(tsd),
      .ocp_i(ocp), .ovp_trip_i(ovp_trip), .ovp_open_lvl_i(ovp_open),
      .ovp_short_lvl_i(ovp_short), .pwm_i(pwm), .ch2_off_i(ch2_off),
      .sw_tick_i(tick), .led_lo_i(lo), .led_hi_i(hi), .ch_en_o(ch_en),
      .shutdown_o(shutdown), .ss_discharge_o(ssd), .fail1_n_o(f1n),
      .fail2_n_o(f2n));

   // Outputs packed as {ch_en[1:0], shutdown, ss_discharge, fail1_n, fail2_n}
   function automatic logic [5:0] outs();
      return {ch_en, shutdown, ssd, f1n, f2n};
   endfunction

   task automatic check(input string req, input logic [5:0] exp);
      n_chk++;
      if (outs() !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, outs(), exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic reenable();
      en = 0; settle(); en = 1; settle();
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      settle();
      // R1 reset state, enable low
      check("R1", 6'b00_11_11);

      // R8 R9 R10: exhaustive sweep of level flags
      for (int v = 0; v < 64; v++) begin
         logic xen, xuv, xts, xov, xoc, xc2, sd;
         {xen, xuv, xts, xov, xoc, xc2} = 6'(v);
         en = xen; uvlo = xuv; tsd = xts; ovp_trip = xov; ocp = xoc; ch2_off = xc2;
         settle();
         sd = ~xen | xuv | xts;
         check("R8_R9_R10_sweep", {~sd & ~xc2, ~sd, sd, sd | xov | xoc,
                                   ~(xuv | xts | xov), 1'b1});
      end
      en = 1; uvlo = 0; tsd = 0; ovp_trip = 0; ocp = 0; ch2_off = 0;
      settle();
      check("R1_enabled", 6'b11_00_11);

      // R4 open on channel 0 latches at once, sticky (R7)
      lo = 2'b01; ovp_open = 1; settle();
      check("R4", 6'b10_00_10);
      lo = 2'b00; ovp_open = 0; settle();
      check("R7_open_sticky", 6'b10_00_10);
      reenable();
      check("R7_open_cleared_by_en", 6'b11_00_11);

      // R10 disabled channel 1 is ignored by open and short-circuit
      ch2_off = 1; lo = 2'b10; ovp_open = 1; settle();
      ticks(Q);
      check("R10_excluded", 6'b01_00_11);
      ch2_off = 0; settle();
      check("R4_R10_reenabled_ch1_open", 6'b01_00_10);
      lo = 2'b00; ovp_open = 0; reenable();

      // R2 short-circuit qualification boundary
      lo = 2'b01; settle();
      ticks(Q-1);
      check("R2_one_short", 6'b11_00_11);
      ticks(1);
      check("R2_latched", 6'b00_11_01);
      lo = 2'b00; settle();
      check("R7_scp_sticky", 6'b00_11_01);
      uvlo = 1; settle(); uvlo = 0; settle();
      check("R7_scp_cleared_by_uvlo", 6'b11_00_11);

      // R3 counter restarts after release
      lo = 2'b10; settle();
      ticks(Q-1);
      lo = 2'b00; settle();
      lo = 2'b10; settle();
      ticks(Q-1);
      check("R3_restarted", 6'b11_00_11);
      ticks(1);
      check("R3_full_count", 6'b00_11_01);
      lo = 2'b00; reenable();

      // R5 R6 short on channel 1 with PWM gating
      hi = 2'b10; ovp_short = 1; pwm = 1; settle();
      ticks(Q-1);
      check("R5_one_short", 6'b11_00_11);
      pwm = 0; settle();
      ticks(3);
      check("R6_pwm_low_holds", 6'b11_00_11);
      pwm = 1; settle();
      ticks(1);
      check("R5_R6_latched_ch1", 6'b01_00_10);
      hi = 2'b00; ovp_short = 0; reenable();
      check("R7_short_cleared", 6'b11_00_11);

      // R5 short counter resets on release (channel 0)
      hi = 2'b01; ovp_short = 1; settle();
      ticks(Q-1);
      hi = 2'b00; settle();
      hi = 2'b01; settle();
      ticks(Q-1);
      check("R5_reset", 6'b11_00_11);
      ticks(1);
      check("R5_latched_ch0", 6'b10_00_10);
      hi = 2'b00; ovp_short = 0; pwm = 0; reenable();

      // R8 overvoltage release is not latched
      ovp_trip = 1; settle();
      check("R8_ovp_on", 6'b11_01_01);
      ovp_trip = 0; settle();
      check("R8_ovp_off", 6'b11_00_11);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule